// File: doc/BRIEF.md
# Dual Stack Pointer Unit

This unit keeps the two stack pointers of a processor core: a normal pointer and an exception pointer. A select input picks the active one. The stack grows upward, so a push raises the active pointer and a pop lowers it, always in steps of eight bytes. A step of eight holds an even-register word at the lower address and an odd-register word four bytes above it. For each request in the current cycle, the unit produces the byte addresses of those two 32-bit words.

Each pointer has a shadow register that holds the pointer minus eight. When the active shadow is valid, a pop is served from it in a single cycle. When the shadow is invalid, the pop is held for one extra cycle while the decrement is computed, and a low ready output tells the pipeline to keep the request steady. Writing a pointer directly invalidates the shadow of that pointer. The unit also forms displacement addresses from the active pointer without changing it. It checks that a dual pop names an even register first and an odd register second.

Top module: `dual_sp_unit`

## Requirements
- R1: After reset both pointers equal RESET_SP, ready is 1, addr_valid is 0 and pair_illegal is 0.
- R2: A push (op code 1) drives even address = active SP and odd address = active SP+4 with addr_valid=1 in the same cycle, and the active SP is eight higher after that clock edge.
- R3: A pop (op code 2) whose active shadow is valid has ready=1 and addr_valid=1 in the same cycle, even address = SP−8 and odd address = SP−4, and the active SP is eight lower after the edge.
- R4: A pop whose active shadow is invalid drives ready=0 and addr_valid=0 for one cycle and leaves SP unchanged. With the request held, it then completes as in R3 in the following cycle.
- R5: Reset leaves both shadows invalid. Any completed push or pop leaves the active shadow valid, so a directly following pop does not stall.
- R6: A transfer (op code 3) loads the pointer chosen by xfer_exc_i (0 normal, 1 exception) with xfer_data_i, clearing its low three bits. Only that pointer changes, addr_valid is 0, and the next pop on that pointer stalls as in R4.
- R7: Push and pop change only the pointer chosen by sel_exc_i (0 normal, 1 exception). The other pointer keeps its value.
- R8: A pop with dual_i=1 whose first register index has bit 0 set, or whose second register index has bit 0 clear, raises pair_illegal. In that cycle it gives ready=1 and addr_valid=0, and it changes no pointer. A single pop (dual_i=0) is never flagged.
- R9: A negative displacement access (op code 4) drives even address = SP − (imm_i[4:0] shifted left 3) when neg_long_i=0, or SP − (imm_i[5:0] shifted left 2) when neg_long_i=1. The odd address is the even address + 4, addr_valid is 1, and SP does not change.
- R10: A positive displacement access (op code 5) drives even address = SP + sign-extended imm_i[14:0], with addr_valid=1, and SP does not change.
- R11: Op codes 0, 6 and 7 are idle. They give addr_valid=0 and ready=1 and change no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Request code (0 idle, 1 push, 2 pop, 3 transfer, 4 negative displacement, 5 positive displacement) |
| sel_exc_i | input | 1 | Active pointer: 0 normal, 1 exception |
| dual_i | input | 1 | Pop names two registers |
| reg_a_i | input | REG_IDX_W | First popped register index |
| reg_b_i | input | REG_IDX_W | Second popped register index |
| xfer_exc_i | input | 1 | Transfer target: 0 normal, 1 exception |
| xfer_data_i | input | ADDR_W | Transfer value |
| imm_i | input | POS_W | Displacement immediate |
| neg_long_i | input | 1 | Negative displacement form: 0 five bits ×8, 1 six bits ×4 |
| ready_o | output | 1 | Low while a pop waits for its decrement |
| addr_valid_o | output | 1 | Address outputs are meaningful this cycle |
| pair_illegal_o | output | 1 | Dual pop register pairing violates even/odd order |
| even_addr_o | output | ADDR_W | Even-register word address |
| odd_addr_o | output | ADDR_W | Odd-register word address |
| sp_norm_o | output | ADDR_W | Normal stack pointer |
| sp_exc_o | output | ADDR_W | Exception stack pointer |

## Verification
Addresses, ready, addr_valid and pair_illegal are combinational from the request and the registered state, so they are due in the same cycle. The bench drives a request at the falling edge and samples these outputs 1 ns later. Pointer values are due one edge after an accepted request, so the bench reads sp_norm_o and sp_exc_o 1 ns after the rising edge. For a pop on an invalid shadow, the bench expects ready low in the first cycle, keeps the request steady, and checks the completed pop one cycle later.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic [2:0] {
      SP_IDLE = 3'd0,
      SP_PUSH = 3'd1,
      SP_POP  = 3'd2,
      SP_XFER = 3'd3,
      SP_DNEG = 3'd4,
      SP_DPOS = 3'd5
   } sp_op_e;

   localparam int unsigned SP_STEP  = 8;
   localparam int unsigned SP_WORD  = 4;
   localparam int unsigned SP_ALIGN = 3;
endpackage

// File: rtl/sp_pair_check.sv
module sp_pair_check #(
   parameter int unsigned REG_IDX_W = 4
) (
   input  logic [REG_IDX_W-1:0] first_idx,
   input  logic [REG_IDX_W-1:0] second_idx,
   output logic                 bad_order
);
   if (REG_IDX_W < 1) begin : g_bad_w
      $error("sp_pair_check: REG_IDX_W must be at least 1");
   end

   // first slot must be even, second slot odd
   assign bad_order = first_idx[0] | ~second_idx[0];
endmodule

// File: rtl/sp_disp_addr.sv
module sp_disp_addr #(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned POS_W        = 15,
   parameter int unsigned NEG_SHORT_W  = 5,
   parameter int unsigned NEG_SHORT_SH = 3,
   parameter int unsigned NEG_LONG_W   = 6,
   parameter int unsigned NEG_LONG_SH  = 2,
   parameter bit          HAS_LONG_NEG = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [POS_W-1:0]  imm,
   input  logic              neg_long,
   output logic [ADDR_W-1:0] neg_addr,
   output logic [ADDR_W-1:0] pos_addr
);
   localparam int unsigned EXT_W = ADDR_W - POS_W;

   if (POS_W >= ADDR_W) begin : g_bad_pos
      $error("sp_disp_addr: POS_W must be below ADDR_W");
   end
   if (NEG_LONG_W > POS_W || NEG_SHORT_W > POS_W) begin : g_bad_neg
      $error("sp_disp_addr: negative immediate wider than imm");
   end

   logic [ADDR_W-1:0] off_short;
   logic [ADDR_W-1:0] off_neg;

   assign off_short = ADDR_W'(imm[NEG_SHORT_W-1:0]) << NEG_SHORT_SH;

   if (HAS_LONG_NEG) begin : g_long
      logic [ADDR_W-1:0] off_long;
      assign off_long = ADDR_W'(imm[NEG_LONG_W-1:0]) << NEG_LONG_SH;
      assign off_neg  = neg_long ? off_long : off_short;
   end else begin : g_short
      logic unused_long;
      assign unused_long = neg_long;
      assign off_neg     = off_short;
   end

   assign neg_addr = base - off_neg;
   assign pos_addr = base + {{EXT_W{imm[POS_W-1]}}, imm};
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
   parameter int unsigned         ADDR_W   = 32,
   parameter logic [ADDR_W-1:0]   RESET_SP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_push,
   input  logic              en_pop,
   input  logic              en_fill,
   input  logic              en_wr,
   input  logic [ADDR_W-1:0] wr_val,
   output logic [ADDR_W-1:0] sp_q,
   output logic [ADDR_W-1:0] sh_q,
   output logic              shv_q
);
   import sp_pkg::*;

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SP_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q  <= RESET_SP;
         sh_q  <= '0;
         shv_q <= 1'b0;
      end else if (en_wr) begin
         sp_q  <= wr_val;
         shv_q <= 1'b0;
      end else if (en_push) begin
         sh_q  <= sp_q;
         sp_q  <= sp_q + STEP;
         shv_q <= 1'b1;
      end else if (en_pop) begin
         sp_q  <= sh_q;
         sh_q  <= sh_q - STEP;
         shv_q <= 1'b1;
      end else if (en_fill) begin
         sh_q  <= sp_q - STEP;
         shv_q <= 1'b1;
      end
   end
endmodule

// File: rtl/dual_sp_unit.sv
module dual_sp_unit
   import sp_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       REG_IDX_W = 4,
   parameter int unsigned       POS_W     = 15,
   parameter logic [ADDR_W-1:0] RESET_SP  = 'h1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2:0]           op_i,
   input  logic                 sel_exc_i,
   input  logic                 dual_i,
   input  logic [REG_IDX_W-1:0] reg_a_i,
   input  logic [REG_IDX_W-1:0] reg_b_i,
   input  logic                 xfer_exc_i,
   input  logic [ADDR_W-1:0]    xfer_data_i,
   input  logic [POS_W-1:0]     imm_i,
   input  logic                 neg_long_i,
   output logic                 ready_o,
   output logic                 addr_valid_o,
   output logic                 pair_illegal_o,
   output logic [ADDR_W-1:0]    even_addr_o,
   output logic [ADDR_W-1:0]    odd_addr_o,
   output logic [ADDR_W-1:0]    sp_norm_o,
   output logic [ADDR_W-1:0]    sp_exc_o
);
   localparam int unsigned N_PTR = 2;
   localparam logic [ADDR_W-1:0] WORD = ADDR_W'(SP_WORD);

   if (ADDR_W < 16) begin : g_bad_addr
      $error("dual_sp_unit: ADDR_W must be at least 16");
   end
   if (RESET_SP[SP_ALIGN-1:0] != '0) begin : g_bad_rst
      $error("dual_sp_unit: RESET_SP must be 8-byte aligned");
   end

   sp_op_e op;
   assign op = sp_op_e'(op_i);

   logic [ADDR_W-1:0] sp_w  [N_PTR];
   logic [ADDR_W-1:0] sh_w  [N_PTR];
   logic              shv_w [N_PTR];

   logic              bad_order;
   logic              pop_ok;
   logic              stall;
   logic [ADDR_W-1:0] act_sp;
   logic [ADDR_W-1:0] act_sh;
   logic              act_shv;
   logic [ADDR_W-1:0] neg_addr;
   logic [ADDR_W-1:0] pos_addr;
   logic [ADDR_W-1:0] wr_val;

   sp_pair_check #(.REG_IDX_W(REG_IDX_W)) u_pair (
      .first_idx  (reg_a_i),
      .second_idx (reg_b_i),
      .bad_order  (bad_order)
   );

   assign act_sp  = sel_exc_i ? sp_w[1]  : sp_w[0];
   assign act_sh  = sel_exc_i ? sh_w[1]  : sh_w[0];
   assign act_shv = sel_exc_i ? shv_w[1] : shv_w[0];

   assign pair_illegal_o = (op == SP_POP) && dual_i && bad_order;
   assign pop_ok         = (op == SP_POP) && !pair_illegal_o;
   assign stall          = pop_ok && !act_shv;
   assign ready_o        = !stall;
   assign wr_val         = {xfer_data_i[ADDR_W-1:SP_ALIGN], {SP_ALIGN{1'b0}}};

   sp_disp_addr #(
      .ADDR_W (ADDR_W),
      .POS_W  (POS_W)
   ) u_disp (
      .base     (act_sp),
      .imm      (imm_i),
      .neg_long (neg_long_i),
      .neg_addr (neg_addr),
      .pos_addr (pos_addr)
   );

   for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
      logic is_act;
      logic is_tgt;
      assign is_act = (sel_exc_i == 1'(i));
      assign is_tgt = (xfer_exc_i == 1'(i));

      sp_bank #(
         .ADDR_W   (ADDR_W),
         .RESET_SP (RESET_SP)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .en_push (is_act && (op == SP_PUSH)),
         .en_pop  (is_act && pop_ok && act_shv),
         .en_fill (is_act && stall),
         .en_wr   (is_tgt && (op == SP_XFER)),
         .wr_val  (wr_val),
         .sp_q    (sp_w[i]),
         .sh_q    (sh_w[i]),
         .shv_q   (shv_w[i])
      );
   end

   always_comb begin
      even_addr_o  = '0;
      addr_valid_o = 1'b0;
      unique case (op)
         SP_PUSH: begin
            even_addr_o  = act_sp;
            addr_valid_o = 1'b1;
         end
         SP_POP: begin
            even_addr_o  = act_sh;
            addr_valid_o = pop_ok && act_shv;
         end
         SP_DNEG: begin
            even_addr_o  = neg_addr;
            addr_valid_o = 1'b1;
         end
         SP_DPOS: begin
            even_addr_o  = pos_addr;
            addr_valid_o = 1'b1;
         end
         default: begin
            even_addr_o  = '0;
            addr_valid_o = 1'b0;
         end
      endcase
   end

   assign odd_addr_o = even_addr_o + WORD;
   assign sp_norm_o  = sp_w[0];
   assign sp_exc_o   = sp_w[1];
endmodule

// File: rtl/dual_sp_unit_sva.sv
module dual_sp_unit_sva #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned REG_IDX_W = 4,
   parameter int unsigned POS_W     = 15
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [2:0]           op_i,
   input logic                 sel_exc_i,
   input logic                 dual_i,
   input logic [REG_IDX_W-1:0] reg_a_i,
   input logic [REG_IDX_W-1:0] reg_b_i,
   input logic                 xfer_exc_i,
   input logic [ADDR_W-1:0]    xfer_data_i,
   input logic [POS_W-1:0]     imm_i,
   input logic                 neg_long_i,
   input logic                 ready_o,
   input logic                 addr_valid_o,
   input logic                 pair_illegal_o,
   input logic [ADDR_W-1:0]    even_addr_o,
   input logic [ADDR_W-1:0]    odd_addr_o,
   input logic [ADDR_W-1:0]    sp_norm_o,
   input logic [ADDR_W-1:0]    sp_exc_o
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2: a normal push raises the normal pointer by eight
   p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd1 && !sel_exc_i) |=> sp_norm_o == $past(sp_norm_o) + 32'd8);

   // R3: a completed normal pop moves the pointer to the even address used
   p_pop_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd2 && addr_valid_o && !sel_exc_i) |=> sp_norm_o == $past(even_addr_o));

   // R4: a stalled pop, held steady, is served on the next cycle
   p_stall_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(!ready_o) && $stable(op_i) && $stable(sel_exc_i)
       && $stable(dual_i) && $stable(reg_a_i) && $stable(reg_b_i)) |-> ready_o);

   // R4: no address is offered while stalled
   p_stall_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |-> !addr_valid_o);

   // R6: pointers stay 8-byte aligned
   p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sp_norm_o[2:0] == 3'd0 && sp_exc_o[2:0] == 3'd0);

   // R8: a flagged pairing changes neither pointer
   p_illegal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pair_illegal_o |=> $stable(sp_norm_o) && $stable(sp_exc_o));

   // R8: a flag only comes with a dual pop
   p_illegal_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pair_illegal_o |-> (op_i == 3'd2 && dual_i && !addr_valid_o));

   // R9 / R10: displacement accesses leave both pointers alone
   p_disp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd4 || op_i == 3'd5) |=> $stable(sp_norm_o) && $stable(sp_exc_o));

   // R7: a push on the exception pointer leaves the normal one alone
   p_other_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == 3'd1 || op_i == 3'd2) && sel_exc_i) |=> $stable(sp_norm_o));
endmodule

bind dual_sp_unit dual_sp_unit_sva #(
   .ADDR_W    (ADDR_W),
   .REG_IDX_W (REG_IDX_W),
   .POS_W     (POS_W)
) u_sva (.*);

// File: tb/dual_sp_unit_test.sv
`timescale 1ns/1ps
module dual_sp_unit_test;
   localparam int unsigned AW = 32;
   localparam logic [31:0] RST_SP = 32'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = '0;
   logic        sel_exc_i = 1'b0;
   logic        dual_i = 1'b0;
   logic [3:0]  reg_a_i = '0;
   logic [3:0]  reg_b_i = '0;
   logic        xfer_exc_i = 1'b0;
   logic [31:0] xfer_data_i = '0;
   logic [14:0] imm_i = '0;
   logic        neg_long_i = 1'b0;
   logic        ready_o, addr_valid_o, pair_illegal_o;
   logic [31:0] even_addr_o, odd_addr_o, sp_norm_o, sp_exc_o;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] m_sp [2];
   bit          m_shv [2];

   always #2 clk = ~clk;

   dual_sp_unit uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] f_neg(input logic [31:0] sp, input logic [14:0] im, input bit lng);
      return lng ? sp - ({26'd0, im[5:0]} << 2) : sp - ({27'd0, im[4:0]} << 3);
   endfunction

   function automatic logic [31:0] f_pos(input logic [31:0] sp, input logic [14:0] im);
      return sp + {{17{im[14]}}, im};
   endfunction

   task automatic apply(input logic [2:0] o, input bit s, input bit d,
                        input logic [3:0] ra, input logic [3:0] rb,
                        input bit xe, input logic [31:0] xd,
                        input logic [14:0] im, input bit nl);
      bit          ill;
      bit          valid_e;
      logic [31:0] ea;
      @(negedge clk);
      op_i = o; sel_exc_i = s; dual_i = d; reg_a_i = ra; reg_b_i = rb;
      xfer_exc_i = xe; xfer_data_i = xd; imm_i = im; neg_long_i = nl;
      #1;
      ill = (o == 3'd2) && d && (ra[0] || !rb[0]);
      chk("R8 pair_illegal", {31'd0, pair_illegal_o}, {31'd0, ill});
      if (o == 3'd2 && !ill && !m_shv[s]) begin
         chk("R4 ready low on cold pop", {31'd0, ready_o}, 32'd0);
         chk("R4 no address while stalled", {31'd0, addr_valid_o}, 32'd0);
         @(posedge clk); #1;
         chk("R4 normal SP held in stall", sp_norm_o, m_sp[0]);
         chk("R4 exception SP held in stall", sp_exc_o, m_sp[1]);
         m_shv[s] = 1'b1;
         @(negedge clk); #1;
      end
      chk("R11 ready", {31'd0, ready_o}, 32'd1);
      ea = '0; valid_e = 1'b0;
      case (o)
         3'd1: begin ea = m_sp[s];          valid_e = 1'b1; end
         3'd2: begin ea = m_sp[s] - 32'd8;  valid_e = !ill; end
         3'd4: begin ea = f_neg(m_sp[s], im, nl); valid_e = 1'b1; end
         3'd5: begin ea = f_pos(m_sp[s], im);     valid_e = 1'b1; end
         default: valid_e = 1'b0;
      endcase
      chk("R11 addr_valid", {31'd0, addr_valid_o}, {31'd0, valid_e});
      if (valid_e) begin
         case (o)
            3'd1: begin chk("R2 push even", even_addr_o, ea); chk("R2 push odd", odd_addr_o, ea + 4); end
            3'd2: begin chk("R3 pop even", even_addr_o, ea);  chk("R3 pop odd", odd_addr_o, ea + 4); end
            3'd4: begin chk("R9 neg disp even", even_addr_o, ea); chk("R9 neg disp odd", odd_addr_o, ea + 4); end
            default: chk("R10 pos disp even", even_addr_o, ea);
         endcase
      end
      case (o)
         3'd1: begin m_sp[s] = m_sp[s] + 32'd8; m_shv[s] = 1'b1; end
         3'd2: if (!ill) begin m_sp[s] = m_sp[s] - 32'd8; m_shv[s] = 1'b1; end
         3'd3: begin m_sp[xe] = {xd[31:3], 3'b000}; m_shv[xe] = 1'b0; end
         default: ;
      endcase
      @(posedge clk); #1;
      chk("R7 normal SP after op", sp_norm_o, m_sp[0]);
      chk("R7 exception SP after op", sp_exc_o, m_sp[1]);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_sp[0] = RST_SP; m_sp[1] = RST_SP; m_shv[0] = 1'b0; m_shv[1] = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 normal SP", sp_norm_o, RST_SP);
      chk("R1 exception SP", sp_exc_o, RST_SP);
      chk("R1 ready", {31'd0, ready_o}, 32'd1);
      chk("R1 addr_valid", {31'd0, addr_valid_o}, 32'd0);
      chk("R1 pair_illegal", {31'd0, pair_illegal_o}, 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R4/R5: first pop after reset stalls, then warm pop does not
      apply(3'd2, 0, 0, 4'd0, 4'd1, 0, 0, 0, 0);
      apply(3'd2, 0, 1, 4'd2, 4'd3, 0, 0, 0, 0);
      // R2 push then R3/R5 pop without stall
      apply(3'd1, 0, 1, 4'd0, 4'd1, 0, 0, 0, 0);
      apply(3'd1, 0, 0, 4'd0, 4'd1, 0, 0, 0, 0);
      apply(3'd2, 0, 1, 4'd4, 4'd5, 0, 0, 0, 0);
      // R7 exception pointer only
      apply(3'd1, 1, 0, 4'd0, 4'd1, 0, 0, 0, 0);
      apply(3'd2, 1, 0, 4'd0, 4'd1, 0, 0, 0, 0);
      // R6 transfer with misaligned data, then cold pop
      apply(3'd3, 0, 0, 4'd0, 4'd1, 1, 32'h0000_2345, 0, 0);
      apply(3'd2, 1, 0, 4'd0, 4'd1, 0, 0, 0, 0);
      apply(3'd3, 0, 0, 4'd0, 4'd1, 0, 32'h8000_0000, 0, 0);
      // R8 bad pairings: odd first, even second
      apply(3'd2, 0, 1, 4'd1, 4'd3, 0, 0, 0, 0);
      apply(3'd2, 0, 1, 4'd2, 4'd4, 0, 0, 0, 0);
      apply(3'd2, 0, 0, 4'd1, 4'd2, 0, 0, 0, 0);
      // R9 both negative forms, R10 negative and positive immediates
      apply(3'd4, 0, 0, 4'd0, 4'd0, 0, 0, 15'h7FFF, 0);
      apply(3'd4, 0, 0, 4'd0, 4'd0, 0, 0, 15'h7FFF, 1);
      apply(3'd5, 0, 0, 4'd0, 4'd0, 0, 0, 15'h4000, 0);
      apply(3'd5, 1, 0, 4'd0, 4'd0, 0, 0, 15'h3FFF, 0);
      // R11 idle codes
      apply(3'd6, 0, 0, 4'd0, 4'd0, 0, 32'hFFFF_FFF8, 0, 0);
      apply(3'd7, 1, 0, 4'd0, 4'd0, 1, 32'hFFFF_FFF8, 0, 0);
      apply(3'd0, 0, 0, 4'd0, 4'd0, 0, 0, 0, 0);

      for (int k = 0; k < 400; k++) begin
         apply(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
               4'($urandom), 4'($urandom), 1'($urandom), $urandom,
               15'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule